// File: doc/BRIEF.md
# Quota-Partitioned Memory-Side Cache Tag Controller

This block holds the tags and makes the allocation decisions for a set-associative cache that sits between all on-chip clients and main memory. Each request names a client, a stream, a line address and an operation. It may also ask for the line to be pinned and may give a sparse-fill stride. The controller looks the address up, reports hit or miss, and on a miss decides whether to allocate a line and which resident line to displace. The data array is not part of this block. Its only output toward data movement is a hit/miss/eviction response one cycle after the request.

Any client hits on any resident line, so one device can write a buffer and another can read it from the cache. Allocation is limited per client by a programmable line quota. A client that has reached its quota may only recycle its own lines. A client below its quota takes free ways first and then lines of clients that are over their quota. Pinned lines are never displaced, and a per-set cap on pinned ways always leaves at least one way replaceable. Large objects can be cached sparsely: only lines whose object index is a multiple of a power-of-two stride are allocated.

Top module: `cmc_ctrl`

## Requirements
- R1: After reset all ways are invalid, no response is valid, every occupancy count is zero, and every quota equals SETS*WAYS.
- R2: `req_ready_o` is always high. An accepted request produces exactly one response on the next cycle, and no response appears in a cycle with no request.
- R3: A lookup hits on a valid line with the same address whatever client allocated it. A hit never allocates and never changes the line's owner.
- R4: On a read (op 0) or write (op 1) miss by a client whose occupancy is below its quota, the lowest-numbered invalid way in the set is allocated and the client's occupancy rises by one.
- R5: A client whose occupancy is at or above its quota may only replace its own least-recently-used unpinned line in the set. If it has none there, the request bypasses (no allocation) and its occupancy is unchanged.
- R6: A client below its quota that finds no invalid way replaces the least-recently-used unpinned line owned by any over-quota client. If no such line exists, the request bypasses.
- R7: Each set keeps a true LRU order, refreshed by every read/write hit and every allocation. Unlock and invalidate do not refresh it.
- R8: A request with the lock hint pins the hit or allocated line unless the set already holds MAX_LOCK pinned ways (default WAYS-1 = 3), in which case the pin is refused. `rsp_locked_o` reports whether the line is pinned after the request. A pinned line is never chosen as a victim.
- R9: An unlock request (op 2) that hits clears the pin, making the line replaceable again. `rsp_hit_o`=1 and `rsp_locked_o`=0.
- R10: On a miss, allocation happens only when the low `req_stride_log_i` bits of `req_obj_idx_i` are all zero. Stride code 0 allocates every line. Other lines bypass.
- R11: A write marks its line dirty. A displacement reports `rsp_evict_o`=1 together with the old line address {tag, set index}, its dirty flag and its stream ID. The set index is the low log2(SETS) address bits.
- R12: An invalidate request (op 3) that hits removes the line, reports it as evicted with its dirty flag, and decrements the owner's occupancy.
- R13: A write on the configuration port sets one client's quota from the next cycle. `occ_o` shows each client's line count, with client c at bits [c*OCC_W +: OCC_W], and the count falls by one for the owner of each displaced line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_client_i | input | CID_W | Requesting client |
| req_stream_i | input | STREAM_W | Stream within the client |
| req_addr_i | input | ADDR_W | Line address; low SET_W bits pick the set |
| req_op_i | input | 2 | 0 read, 1 write, 2 unlock, 3 invalidate |
| req_lock_i | input | 1 | Pin hint for read/write |
| req_stride_log_i | input | SLOG_W | log2 of sparse-fill stride |
| req_obj_idx_i | input | IDX_W | Line index within the object |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Tag matched |
| rsp_alloc_o | output | 1 | A line was allocated |
| rsp_locked_o | output | 1 | Line pinned after the request |
| rsp_evict_o | output | 1 | A resident line was displaced or invalidated |
| rsp_evict_addr_o | output | ADDR_W | Address of the displaced line |
| rsp_evict_dirty_o | output | 1 | Displaced line was dirty |
| rsp_evict_stream_o | output | STREAM_W | Stream of the displaced line |
| cfg_we_i | input | 1 | Quota write strobe |
| cfg_client_i | input | CID_W | Client whose quota is written |
| cfg_quota_i | input | OCC_W | New quota in lines |
| occ_o | output | CLIENTS*OCC_W | Per-client occupancy |

## Verification
The bench targets the cases where a quota rule can leak. In one, a client at quota tries to take a free way or a foreign line; a faulty design would grow that client's occupancy past its quota or evict someone else's line. In another, a client below quota meets a full set whose owners are all within quota; it must bypass rather than evict. The bench refreshes the oldest line with a hit before displacement, so an LRU that ignores hits evicts the wrong address. It also fills a set with pinned lines: a design that picks pinned ways, or ignores the pin cap, evicts the wrong line or reports a pin that must be refused. Sparse indices just off and exactly on a stride multiple, an unlock that should not refresh age, and an invalidate that must return the dirty flag and lower occupancy complete the set.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [1:0] {
    OP_RD     = 2'd0,
    OP_WR     = 2'd1,
    OP_UNLOCK = 2'd2,
    OP_INVAL  = 2'd3
  } cmc_op_e;
endpackage

// File: rtl/cmc_lru.sv
// Per-set true LRU as age ranks: 0 = most recent, WAYS-1 = oldest.
module cmc_lru #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int SET_W = 2,
  parameter int WAY_W = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [SET_W-1:0]            rd_set_i,
  output logic [WAYS-1:0][WAY_W-1:0]  age_o,
  input  logic                        touch_i,
  input  logic [SET_W-1:0]            touch_set_i,
  input  logic [WAY_W-1:0]            touch_way_i
);
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q, age_d;
  logic [WAY_W-1:0] old_age;

  assign old_age = age_q[touch_set_i][touch_way_i];

  always_comb begin
    age_d = age_q;
    if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (w == int'(touch_way_i))
          age_d[touch_set_i][w] = '0;
        else if (age_q[touch_set_i][w] < old_age)
          age_d[touch_set_i][w] = age_q[touch_set_i][w] + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else begin
      age_q <= age_d;
    end
  end

  assign age_o = age_q[rd_set_i];
endmodule

// File: rtl/cmc_quota.sv
// Quota registers and occupancy counters, one slice per client.
module cmc_quota #(
  parameter int CLIENTS   = 4,
  parameter int CID_W     = 2,
  parameter int OCC_W     = 5,
  parameter int DEF_QUOTA = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cfg_we_i,
  input  logic [CID_W-1:0]                cfg_client_i,
  input  logic [OCC_W-1:0]                cfg_quota_i,
  input  logic                            inc_i,
  input  logic [CID_W-1:0]                inc_client_i,
  input  logic                            dec_i,
  input  logic [CID_W-1:0]                dec_client_i,
  output logic [CLIENTS-1:0][OCC_W-1:0]   occ_o,
  output logic [CLIENTS-1:0][OCC_W-1:0]   quota_o
);
  for (genvar c = 0; c < CLIENTS; c++) begin : g_cl
    logic [OCC_W-1:0] occ_r, quota_r;
    logic up, down;
    assign up   = inc_i && (inc_client_i == CID_W'(c));
    assign down = dec_i && (dec_client_i == CID_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        occ_r   <= '0;
        quota_r <= OCC_W'(DEF_QUOTA);
      end else begin
        if (cfg_we_i && cfg_client_i == CID_W'(c)) quota_r <= cfg_quota_i;
        case ({up, down})
          2'b10:   occ_r <= occ_r + OCC_W'(1);
          2'b01:   occ_r <= occ_r - OCC_W'(1);
          default: ;
        endcase
      end
    end

    assign occ_o[c]   = occ_r;
    assign quota_o[c] = quota_r;
  end
endmodule

// File: rtl/cmc_victim.sv
// Victim choice for one set under the quota rules.
module cmc_victim #(
  parameter int WAYS    = 4,
  parameter int WAY_W   = 2,
  parameter int CLIENTS = 4,
  parameter int CID_W   = 2,
  parameter int OCC_W   = 5
) (
  input  logic [WAYS-1:0]                valid_i,
  input  logic [WAYS-1:0]                lock_i,
  input  logic [WAYS-1:0][CID_W-1:0]     owner_i,
  input  logic [WAYS-1:0][WAY_W-1:0]     age_i,
  input  logic [CLIENTS-1:0][OCC_W-1:0]  occ_i,
  input  logic [CLIENTS-1:0][OCC_W-1:0]  quota_i,
  input  logic [CID_W-1:0]               req_client_i,
  output logic                           under_o,
  output logic                           found_o,
  output logic [WAY_W-1:0]               way_o
);
  logic [WAYS-1:0] own_m, over_m, inv_m, cand_m;
  logic use_inv;
  logic [WAY_W-1:0] best_age;

  always_comb begin
    under_o = occ_i[req_client_i] < quota_i[req_client_i];
    for (int w = 0; w < WAYS; w++) begin
      own_m[w]  = valid_i[w] && !lock_i[w] && (owner_i[w] == req_client_i);
      over_m[w] = valid_i[w] && !lock_i[w] &&
                  (occ_i[owner_i[w]] > quota_i[owner_i[w]]);
    end
    inv_m   = ~valid_i;
    use_inv = under_o && (|inv_m);
    cand_m  = under_o ? over_m : own_m;

    found_o  = 1'b0;
    way_o    = '0;
    best_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (use_inv) begin
        if (inv_m[w] && !found_o) begin
          found_o = 1'b1;
          way_o   = WAY_W'(w);
        end
      end else if (cand_m[w] && (!found_o || age_i[w] > best_age)) begin
        found_o  = 1'b1;
        way_o    = WAY_W'(w);
        best_age = age_i[w];
      end
    end
  end
endmodule

// File: rtl/cmc_ctrl.sv
module cmc_ctrl
  import cmc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SETS      = 4,
  parameter int WAYS      = 4,
  parameter int CLIENTS   = 4,
  parameter int STREAM_W  = 4,
  parameter int IDX_W     = 8,
  parameter int MAX_LOCK  = WAYS - 1,
  parameter int DEF_QUOTA = SETS * WAYS,
  localparam int SET_W    = $clog2(SETS),
  localparam int TAG_W    = ADDR_W - SET_W,
  localparam int WAY_W    = $clog2(WAYS),
  localparam int CID_W    = $clog2(CLIENTS),
  localparam int SLOG_W   = $clog2(IDX_W),
  localparam int OCC_W    = $clog2(SETS * WAYS + 1),
  localparam int LCNT_W   = $clog2(WAYS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [CID_W-1:0]          req_client_i,
  input  logic [STREAM_W-1:0]       req_stream_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [1:0]                req_op_i,
  input  logic                      req_lock_i,
  input  logic [SLOG_W-1:0]         req_stride_log_i,
  input  logic [IDX_W-1:0]          req_obj_idx_i,
  output logic                      rsp_valid_o,
  output logic                      rsp_hit_o,
  output logic                      rsp_alloc_o,
  output logic                      rsp_locked_o,
  output logic                      rsp_evict_o,
  output logic [ADDR_W-1:0]         rsp_evict_addr_o,
  output logic                      rsp_evict_dirty_o,
  output logic [STREAM_W-1:0]       rsp_evict_stream_o,
  input  logic                      cfg_we_i,
  input  logic [CID_W-1:0]          cfg_client_i,
  input  logic [OCC_W-1:0]          cfg_quota_i,
  output logic [CLIENTS*OCC_W-1:0]  occ_o
);
  cmc_op_e op;
  assign op          = cmc_op_e'(req_op_i);
  assign req_ready_o = 1'b1;

  // tag store
  logic [SETS-1:0][WAYS-1:0]                valid_q, lock_q, dirty_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]     tag_q;
  logic [SETS-1:0][WAYS-1:0][CID_W-1:0]     owner_q;
  logic [SETS-1:0][WAYS-1:0][STREAM_W-1:0]  stream_q;

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  assign set_idx = req_addr_i[SET_W-1:0];
  assign req_tag = req_addr_i[ADDR_W-1:SET_W];

  logic [WAYS-1:0]                set_valid, set_lock, set_dirty;
  logic [WAYS-1:0][TAG_W-1:0]     set_tag;
  logic [WAYS-1:0][CID_W-1:0]     set_owner;
  logic [WAYS-1:0][STREAM_W-1:0]  set_stream;
  assign set_valid  = valid_q[set_idx];
  assign set_lock   = lock_q[set_idx];
  assign set_dirty  = dirty_q[set_idx];
  assign set_tag    = tag_q[set_idx];
  assign set_owner  = owner_q[set_idx];
  assign set_stream = stream_q[set_idx];

  // lookup
  logic [WAYS-1:0]  hit_vec;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = set_valid[w] && (set_tag[w] == req_tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
  assign hit = |hit_vec;

  logic [LCNT_W-1:0] lock_cnt;
  logic              lock_room;
  assign lock_cnt  = LCNT_W'($countones(set_lock));
  assign lock_room = lock_cnt < LCNT_W'(MAX_LOCK);

  logic [IDX_W-1:0] idx_mask;
  logic             sparse_ok;
  assign idx_mask  = ~({IDX_W{1'b1}} << req_stride_log_i);
  assign sparse_ok = (req_obj_idx_i & idx_mask) == '0;

  // replacement and quota state
  logic [WAYS-1:0][WAY_W-1:0]      set_age;
  logic [CLIENTS-1:0][OCC_W-1:0]   occ, quota;
  logic                            vic_found, req_under;
  logic [WAY_W-1:0]                vic_way;

  logic is_access, fire, alloc_en, evict_alloc, inval_en, unlock_en;
  logic lock_on_hit, alloc_lock, touch, evict_any;
  logic [WAY_W-1:0] ev_way;
  logic [CID_W-1:0] dec_client;

  assign fire        = req_valid_i;
  assign is_access   = (op == OP_RD) || (op == OP_WR);
  assign alloc_en    = fire && is_access && !hit && sparse_ok && vic_found;
  assign evict_alloc = alloc_en && set_valid[vic_way];
  assign inval_en    = fire && (op == OP_INVAL) && hit;
  assign unlock_en   = fire && (op == OP_UNLOCK) && hit;
  assign lock_on_hit = fire && is_access && hit && req_lock_i &&
                       !set_lock[hit_way] && lock_room;
  assign alloc_lock  = req_lock_i && lock_room;
  assign touch       = fire && is_access && (hit || alloc_en);
  assign evict_any   = evict_alloc || inval_en;
  assign ev_way      = inval_en ? hit_way : vic_way;
  assign dec_client  = set_owner[ev_way];

  cmc_lru #(
    .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_set_i   (set_idx),
    .age_o      (set_age),
    .touch_i    (touch),
    .touch_set_i(set_idx),
    .touch_way_i(hit ? hit_way : vic_way)
  );

  cmc_quota #(
    .CLIENTS(CLIENTS), .CID_W(CID_W), .OCC_W(OCC_W), .DEF_QUOTA(DEF_QUOTA)
  ) u_quota (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_client_i(cfg_client_i),
    .cfg_quota_i (cfg_quota_i),
    .inc_i       (alloc_en),
    .inc_client_i(req_client_i),
    .dec_i       (evict_any),
    .dec_client_i(dec_client),
    .occ_o       (occ),
    .quota_o     (quota)
  );

  cmc_victim #(
    .WAYS(WAYS), .WAY_W(WAY_W), .CLIENTS(CLIENTS), .CID_W(CID_W), .OCC_W(OCC_W)
  ) u_victim (
    .valid_i     (set_valid),
    .lock_i      (set_lock),
    .owner_i     (set_owner),
    .age_i       (set_age),
    .occ_i       (occ),
    .quota_i     (quota),
    .req_client_i(req_client_i),
    .under_o     (req_under),
    .found_o     (vic_found),
    .way_o       (vic_way)
  );

  // tag store update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      lock_q   <= '0;
      dirty_q  <= '0;
      tag_q    <= '0;
      owner_q  <= '0;
      stream_q <= '0;
    end else begin
      if (alloc_en) begin
        valid_q[set_idx][vic_way]  <= 1'b1;
        tag_q[set_idx][vic_way]    <= req_tag;
        owner_q[set_idx][vic_way]  <= req_client_i;
        stream_q[set_idx][vic_way] <= req_stream_i;
        dirty_q[set_idx][vic_way]  <= (op == OP_WR);
        lock_q[set_idx][vic_way]   <= alloc_lock;
      end
      if (fire && hit && op == OP_WR) dirty_q[set_idx][hit_way] <= 1'b1;
      if (lock_on_hit) lock_q[set_idx][hit_way] <= 1'b1;
      if (unlock_en)   lock_q[set_idx][hit_way] <= 1'b0;
      if (inval_en) begin
        valid_q[set_idx][hit_way] <= 1'b0;
        lock_q[set_idx][hit_way]  <= 1'b0;
        dirty_q[set_idx][hit_way] <= 1'b0;
      end
    end
  end

  // response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o        <= 1'b0;
      rsp_hit_o          <= 1'b0;
      rsp_alloc_o        <= 1'b0;
      rsp_locked_o       <= 1'b0;
      rsp_evict_o        <= 1'b0;
      rsp_evict_addr_o   <= '0;
      rsp_evict_dirty_o  <= 1'b0;
      rsp_evict_stream_o <= '0;
    end else begin
      rsp_valid_o  <= fire;
      rsp_hit_o    <= fire && hit;
      rsp_alloc_o  <= alloc_en;
      rsp_locked_o <= fire && is_access &&
                      (hit ? (set_lock[hit_way] || lock_on_hit) : (alloc_en && alloc_lock));
      rsp_evict_o        <= evict_any;
      rsp_evict_addr_o   <= evict_any ? {set_tag[ev_way], set_idx} : '0;
      rsp_evict_dirty_o  <= evict_any && set_dirty[ev_way];
      rsp_evict_stream_o <= evict_any ? set_stream[ev_way] : '0;
    end
  end

  for (genvar c = 0; c < CLIENTS; c++) begin : g_occ
    assign occ_o[c*OCC_W +: OCC_W] = occ[c];
  end
endmodule

// File: rtl/cmc_ctrl_chk.sv
module cmc_ctrl_chk #(
  parameter int WAYS     = 4,
  parameter int CID_W    = 2,
  parameter int IDX_W    = 8,
  parameter int SLOG_W   = 3,
  parameter int MAX_LOCK = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [CID_W-1:0]  req_client_i,
  input logic [SLOG_W-1:0] req_stride_log_i,
  input logic [IDX_W-1:0]  req_obj_idx_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              rsp_alloc_o,
  input logic [WAYS-1:0]   set_lock_i,
  input logic              alloc_en_i,
  input logic              vic_valid_i,
  input logic              vic_lock_i,
  input logic [CID_W-1:0]  vic_owner_i,
  input logic              req_under_i
);
  logic [IDX_W-1:0] low_bits;
  logic             on_stride;
  assign low_bits  = req_obj_idx_i & ~({IDX_W{1'b1}} << req_stride_log_i);
  assign on_stride = ~|low_bits;

  assert_rsp_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_no_rsp_when_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_hit_no_alloc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> !rsp_alloc_o);
  assert_no_foreign_evict_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_en_i && vic_valid_i && !req_under_i) |-> (vic_owner_i == req_client_i));
  assert_no_locked_victim_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_en_i && vic_valid_i) |-> !vic_lock_i);
  assert_lock_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> ($countones(set_lock_i) <= MAX_LOCK));
  assert_sparse_alloc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_alloc_o |-> $past(on_stride)));
endmodule

bind cmc_ctrl cmc_ctrl_chk #(
  .WAYS(WAYS), .CID_W(CID_W), .IDX_W(IDX_W), .SLOG_W(SLOG_W), .MAX_LOCK(MAX_LOCK)
) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_client_i    (req_client_i),
  .req_stride_log_i(req_stride_log_i),
  .req_obj_idx_i   (req_obj_idx_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_hit_o       (rsp_hit_o),
  .rsp_alloc_o     (rsp_alloc_o),
  .set_lock_i      (set_lock),
  .alloc_en_i      (alloc_en),
  .vic_valid_i     (set_valid[vic_way]),
  .vic_lock_i      (set_lock[vic_way]),
  .vic_owner_i     (set_owner[vic_way]),
  .req_under_i     (req_under)
);

// File: tb/cmc_ctrl_tb_top.sv
module cmc_ctrl_tb_top;
  localparam int ADDR_W   = 12;
  localparam int CLIENTS  = 4;
  localparam int STREAM_W = 4;
  localparam int IDX_W    = 8;
  localparam int CID_W    = 2;
  localparam int SLOG_W   = 3;
  localparam int OCC_W    = 5;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, UL = 2'd2, INV = 2'd3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [CID_W-1:0] req_client_i = '0;
  logic [STREAM_W-1:0] req_stream_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [1:0] req_op_i = '0;
  logic req_lock_i = 1'b0;
  logic [SLOG_W-1:0] req_stride_log_i = '0;
  logic [IDX_W-1:0] req_obj_idx_i = '0;
  logic rsp_valid_o, rsp_hit_o, rsp_alloc_o, rsp_locked_o, rsp_evict_o, rsp_evict_dirty_o;
  logic [ADDR_W-1:0] rsp_evict_addr_o;
  logic [STREAM_W-1:0] rsp_evict_stream_o;
  logic cfg_we_i = 1'b0;
  logic [CID_W-1:0] cfg_client_i = '0;
  logic [OCC_W-1:0] cfg_quota_i = '0;
  logic [CLIENTS*OCC_W-1:0] occ_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 20 ns period

  cmc_ctrl dut_i (.*);

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
    return ADDR_W'(tag * 4 + set);
  endfunction

  function automatic int occ_of(input int c);
    return int'(occ_o[c*OCC_W +: OCC_W]);
  endfunction

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic issue(input int cl, input logic [1:0] op, input logic [ADDR_W-1:0] a,
                       input logic lk, input int slog, input int idx, input int st);
    @(negedge clk_i);
    req_valid_i      = 1'b1;
    req_client_i     = CID_W'(cl);
    req_op_i         = op;
    req_addr_i       = a;
    req_lock_i       = lk;
    req_stride_log_i = SLOG_W'(slog);
    req_obj_idx_i    = IDX_W'(idx);
    req_stream_i     = STREAM_W'(st);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    req_lock_i  = 1'b0;
  endtask

  task automatic rd(input int cl, input logic [ADDR_W-1:0] a, input logic lk);
    issue(cl, RD, a, lk, 0, 0, cl);
  endtask

  task automatic set_quota(input int cl, input int q);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_client_i = CID_W'(cl); cfg_quota_i = OCC_W'(q);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "rsp_valid in reset", rsp_valid_o, 0);
    for (int c = 0; c < CLIENTS; c++) chk("R1", "occ in reset", occ_of(c), 0);
    chk("R2", "ready", req_ready_o, 1);
  endtask

  task automatic t_handoff;
    issue(0, WR, mk(1, 0), 1'b0, 0, 0, 5);
    chk("R2", "rsp_valid", rsp_valid_o, 1);
    chk("R1", "first access misses", rsp_hit_o, 0);
    chk("R4", "alloc on miss", rsp_alloc_o, 1);
    chk("R4", "no evict into free way", rsp_evict_o, 0);
    chk("R4", "occ0", occ_of(0), 1);
    @(negedge clk_i);
    chk("R2", "no rsp when idle", rsp_valid_o, 0);
    rd(1, mk(1, 0), 1'b0);
    chk("R3", "cross-client hit", rsp_hit_o, 1);
    chk("R3", "hit no alloc", rsp_alloc_o, 0);
    chk("R3", "occ1 unchanged", occ_of(1), 0);
  endtask

  task automatic t_own_quota;
    set_quota(2, 1);
    rd(2, mk(1, 1), 1'b0);
    chk("R13", "alloc under new quota", rsp_alloc_o, 1);
    rd(2, mk(2, 1), 1'b0);
    chk("R5", "at quota recycles own", rsp_evict_o, 1);
    chk("R5", "evict addr", rsp_evict_addr_o, mk(1, 1));
    chk("R5", "occ2 held", occ_of(2), 1);
    issue(2, WR, mk(2, 1), 1'b0, 0, 0, 2);
    chk("R11", "write hit", rsp_hit_o, 1);
    rd(2, mk(1, 1), 1'b0);
    chk("R3", "evicted line misses", rsp_hit_o, 0);
    chk("R11", "evict addr", rsp_evict_addr_o, mk(2, 1));
    chk("R11", "dirty after write hit", rsp_evict_dirty_o, 1);
  endtask

  task automatic t_zero_quota;
    set_quota(3, 0);
    rd(3, mk(1, 2), 1'b0);
    chk("R5", "zero quota bypass", rsp_alloc_o, 0);
    chk("R5", "occ3", occ_of(3), 0);
    rd(3, mk(1, 2), 1'b0);
    chk("R5", "still miss", rsp_hit_o, 0);
  endtask

  task automatic t_sparse;
    issue(0, RD, mk(2, 2), 1'b0, 2, 5, 0);
    chk("R10", "off-stride bypass", rsp_alloc_o, 0);
    issue(0, RD, mk(2, 2), 1'b0, 2, 5, 0);
    chk("R10", "off-stride not cached", rsp_hit_o, 0);
    issue(0, RD, mk(3, 2), 1'b0, 2, 8, 0);
    chk("R10", "on-stride alloc", rsp_alloc_o, 1);
    chk("R10", "occ0", occ_of(0), 2);
  endtask

  task automatic t_over_quota_lru;
    for (int t = 1; t <= 4; t++) rd(1, mk(t, 3), 1'b0);
    chk("R4", "occ1 filled", occ_of(1), 4);
    rd(1, mk(1, 3), 1'b0);
    chk("R7", "refresh hit", rsp_hit_o, 1);
    set_quota(1, 2);
    rd(0, mk(5, 3), 1'b0);
    chk("R6", "take over-quota line", rsp_alloc_o, 1);
    chk("R7", "LRU victim after refresh", rsp_evict_addr_o, mk(2, 3));
    chk("R13", "occ1 down", occ_of(1), 3);
    chk("R13", "occ0 up", occ_of(0), 3);
  endtask

  task automatic t_no_victim;
    set_quota(1, 3);
    rd(0, mk(6, 3), 1'b0);
    chk("R6", "no eligible bypass", rsp_alloc_o, 0);
    chk("R6", "no evict", rsp_evict_o, 0);
  endtask

  task automatic t_lock;
    rd(0, mk(1, 0), 1'b1);
    chk("R8", "pin on hit", rsp_locked_o, 1);
    rd(0, mk(2, 0), 1'b1);
    chk("R8", "pin on alloc 2", rsp_locked_o, 1);
    rd(0, mk(3, 0), 1'b1);
    chk("R8", "pin on alloc 3", rsp_locked_o, 1);
    rd(0, mk(4, 0), 1'b1);
    chk("R8", "pin cap refused", rsp_locked_o, 0);
    chk("R8", "still allocated", rsp_alloc_o, 1);
    chk("R13", "occ0", occ_of(0), 6);
    set_quota(0, occ_of(0));
    rd(0, mk(5, 0), 1'b0);
    chk("R8", "skip pinned ways", rsp_evict_addr_o, mk(4, 0));
    chk("R5", "own evict", rsp_evict_o, 1);
  endtask

  task automatic t_unlock;
    issue(0, UL, mk(1, 0), 1'b0, 0, 0, 0);
    chk("R9", "unlock hit", rsp_hit_o, 1);
    chk("R9", "unpinned", rsp_locked_o, 0);
    rd(0, mk(6, 0), 1'b0);
    chk("R9", "unlocked line replaceable", rsp_evict_addr_o, mk(1, 0));
    chk("R11", "dirty from write alloc", rsp_evict_dirty_o, 1);
    chk("R11", "evict stream", rsp_evict_stream_o, 5);
  endtask

  task automatic t_inval;
    issue(0, INV, mk(6, 0), 1'b0, 0, 0, 0);
    chk("R12", "inval hit", rsp_hit_o, 1);
    chk("R12", "inval evict", rsp_evict_o, 1);
    chk("R12", "inval addr", rsp_evict_addr_o, mk(6, 0));
    chk("R12", "clean", rsp_evict_dirty_o, 0);
    chk("R12", "occ0 down", occ_of(0), 5);
    rd(0, mk(6, 0), 1'b0);
    chk("R12", "gone", rsp_hit_o, 0);
    chk("R4", "refill free way", rsp_evict_o, 0);
    chk("R4", "occ0 back", occ_of(0), 6);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_handoff();
    t_own_quota();
    t_zero_quota();
    t_sparse();
    t_over_quota_lru();
    t_no_victim();
    t_lock();
    t_unlock();
    t_inval();
    repeat (2) @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule